// File: doc/BRIEF.md
# Predictive Square Search Controller

This block sequences the candidate motion vectors for one 32x32 block of a block-matching motion estimator. On `start` it takes the motion vectors of three already-processed neighbours (left, above, above-right) and forms a median predictor from them. It then sends candidate vectors, one at a time, to an external matching-cost engine and collects one distortion value per candidate. From those costs it walks a shrinking square search pattern and returns the converged vector with its cost.

The search first tries the predictor with a step-4 square. If the predictor looks good, the search refines it with step-2 and then step-1 squares. If it does not, the search starts again from the zero vector with step-8 squares. These squares move toward the lowest cost until the centre wins, and then steps 4, 2 and 1 follow. Pixel fetch and cost arithmetic are outside the block. A programmable threshold sets how lenient the predictor test is.

Top module: `sq_search_ctrl`

## Requirements
- R1: The first candidate of every search is the component-wise median of the left, upper and upper-right neighbour vectors.
- R2: A square pattern of step s is issued as the centre first, then the eight neighbours in this order: (-s,-s), (0,-s), (+s,-s), (-s,0), (+s,0), (-s,+s), (0,+s), (+s,+s), given as (dx,dy) offsets from the centre.
- R3: After the step-4 pattern around the predictor, the predictor is accepted when the pattern minimum is its centre, or when that minimum cost is strictly below `thresh`. On acceptance, step-2 and step-1 patterns follow and `pred_used` is reported as 1.
- R4: On rejection, the next candidate is the zero vector and step-8 patterns run. Each step-8 pattern whose minimum is not its centre is repeated around its best point. Once the centre is the minimum, patterns of step 4, 2 and 1 follow, and `pred_used` is reported as 0.
- R5: A candidate with either component outside [-RANGE, +RANGE] (default ±128) is skipped and is never presented on `cand_x`/`cand_y`.
- R6: A pattern whose centre is the best point of the previous pattern reuses that cost and does not re-issue the centre. The centre is issued only for the predictor and for the zero vector after rejection.
- R7: When costs are equal, the candidate evaluated earlier is kept. A pattern's centre therefore beats any later tie.
- R8: Only one candidate is outstanding at a time. A presented candidate holds stable until `cand_ready`, and no new candidate appears until `cost_valid` returns its cost.
- R9: `done` pulses high for exactly one cycle with `mv_x`, `mv_y`, `mv_cost` and `pred_used` valid. A `start` pulse during a search is ignored.
- R10: After reset, `cand_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search for one block (ignored while searching) |
| left_x | input | MVW | Left neighbour vector, horizontal (signed) |
| left_y | input | MVW | Left neighbour vector, vertical (signed) |
| up_x | input | MVW | Upper neighbour vector, horizontal |
| up_y | input | MVW | Upper neighbour vector, vertical |
| upr_x | input | MVW | Upper-right neighbour vector, horizontal |
| upr_y | input | MVW | Upper-right neighbour vector, vertical |
| thresh | input | CW | Predictor acceptance threshold |
| cand_valid | output | 1 | Candidate vector presented |
| cand_ready | input | 1 | Cost engine accepts the candidate |
| cand_x | output | MVW | Candidate vector, horizontal |
| cand_y | output | MVW | Candidate vector, vertical |
| cost_valid | input | 1 | Cost of the outstanding candidate is present |
| cost | input | CW | Distortion of the outstanding candidate |
| done | output | 1 | One-cycle completion pulse |
| mv_x | output | MVW | Final vector, horizontal |
| mv_y | output | MVW | Final vector, vertical |
| mv_cost | output | CW | Cost of the final vector |
| pred_used | output | 1 | 1 when the predictor path was taken |

## Verification
A corrupted centre, step or pattern index appears at once on the candidate stream. The first wrong vector shows up on `cand_x`/`cand_y` within the same pattern, so the bench records the order of candidates and counts them per search. A wrong best-point or phase record stays hidden until a pattern ends. It then shows up as a wrong next centre, a wrong `pred_used`, or a wrong final vector and cost at `done`. The bench compares all of these with an independent model of the walk under flat, convex, tied and range-edge cost surfaces.

// File: rtl/sq_search_ctrl.sv
`timescale 1ns/1ps
module sq_search_ctrl #(
  parameter int MVW   = 9,
  parameter int CW    = 16,
  parameter int RANGE = 128
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic signed [MVW-1:0] left_x,
  input  logic signed [MVW-1:0] left_y,
  input  logic signed [MVW-1:0] up_x,
  input  logic signed [MVW-1:0] up_y,
  input  logic signed [MVW-1:0] upr_x,
  input  logic signed [MVW-1:0] upr_y,
  input  logic [CW-1:0]         thresh,
  output logic                  cand_valid,
  input  logic                  cand_ready,
  output logic signed [MVW-1:0] cand_x,
  output logic signed [MVW-1:0] cand_y,
  input  logic                  cost_valid,
  input  logic [CW-1:0]         cost,
  output logic                  done,
  output logic signed [MVW-1:0] mv_x,
  output logic signed [MVW-1:0] mv_y,
  output logic [CW-1:0]         mv_cost,
  output logic                  pred_used
);
  localparam int EW = MVW + 2;
  localparam logic signed [EW-1:0] LIM = EW'(RANGE);
  localparam logic [1:0] PH_PRED = 2'd0, PH_COARSE = 2'd1, PH_CONV = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_EVAL} state_t;
  state_t state;

  logic signed [MVW-1:0] cx, cy, bx, by;
  logic [CW-1:0]         bc;
  logic [3:0]            step, idx;
  logic [1:0]            phase;
  logic                  at_ctr, took_pred;
  logic signed [EW-1:0]  st, dx, dy, px, py;
  logic                  inr;

  function automatic logic signed [MVW-1:0] med3(input logic signed [MVW-1:0] a,
                                                  input logic signed [MVW-1:0] b,
                                                  input logic signed [MVW-1:0] c);
    logic signed [MVW-1:0] lo, hi;
    lo = (a < b) ? a : b;
    hi = (a < b) ? b : a;
    return (c < lo) ? lo : ((c > hi) ? hi : c);
  endfunction

  assign st = EW'(step);

  always_comb begin
    case (idx)
      4'd1, 4'd4, 4'd6: dx = -st;
      4'd3, 4'd5, 4'd8: dx = st;
      default:          dx = '0;
    endcase
    case (idx)
      4'd1, 4'd2, 4'd3: dy = -st;
      4'd6, 4'd7, 4'd8: dy = st;
      default:          dy = '0;
    endcase
    px = EW'(cx) + dx;
    py = EW'(cy) + dy;
  end

  assign inr        = (px >= -LIM) && (px <= LIM) && (py >= -LIM) && (py <= LIM);
  assign cand_valid = (state == S_ISSUE) && (idx != 4'd9) && inr;
  assign cand_x     = px[MVW-1:0];
  assign cand_y     = py[MVW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cx        <= '0;
      cy        <= '0;
      bx        <= '0;
      by        <= '0;
      bc        <= '0;
      step      <= 4'd4;
      idx       <= '0;
      phase     <= PH_PRED;
      at_ctr    <= 1'b0;
      took_pred <= 1'b0;
      done      <= 1'b0;
      mv_x      <= '0;
      mv_y      <= '0;
      mv_cost   <= '0;
      pred_used <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          cx        <= med3(left_x, up_x, upr_x);
          cy        <= med3(left_y, up_y, upr_y);
          step      <= 4'd4;
          phase     <= PH_PRED;
          idx       <= '0;
          took_pred <= 1'b0;
          state     <= S_ISSUE;
        end
        S_ISSUE: begin
          if (idx == 4'd9)     state <= S_EVAL;
          else if (!inr)       idx   <= idx + 4'd1;
          else if (cand_ready) state <= S_WAIT;
        end
        S_WAIT: if (cost_valid) begin
          if (idx == 4'd0 || cost < bc) begin
            bx     <= px[MVW-1:0];
            by     <= py[MVW-1:0];
            bc     <= cost;
            at_ctr <= (idx == 4'd0);
          end
          idx   <= idx + 4'd1;
          state <= S_ISSUE;
        end
        S_EVAL: begin
          idx    <= 4'd1;
          at_ctr <= 1'b1;
          state  <= S_ISSUE;
          cx     <= bx;
          cy     <= by;
          case (phase)
            PH_PRED: begin
              if (at_ctr || bc < thresh) begin
                took_pred <= 1'b1;
                step      <= 4'd2;
                phase     <= PH_CONV;
              end else begin
                cx    <= '0;
                cy    <= '0;
                idx   <= '0;
                step  <= 4'd8;
                phase <= PH_COARSE;
              end
            end
            PH_COARSE: if (at_ctr) begin
              step  <= 4'd4;
              phase <= PH_CONV;
            end
            default: begin
              if (step == 4'd1) begin
                state     <= S_IDLE;
                done      <= 1'b1;
                mv_x      <= bx;
                mv_y      <= by;
                mv_cost   <= bc;
                pred_used <= took_pred;
              end else begin
                step <= step >> 1;
              end
            end
          endcase
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sq_search_ctrl_chk.sv
`timescale 1ns/1ps
module sq_search_ctrl_chk #(
  parameter int MVW   = 9,
  parameter int RANGE = 128
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cand_valid,
  input logic                  cand_ready,
  input logic signed [MVW-1:0] cand_x,
  input logic signed [MVW-1:0] cand_y,
  input logic                  cost_valid,
  input logic                  done
);
  logic outstanding;

  always_ff @(posedge clk) begin
    if (!rst_n)                        outstanding <= 1'b0;
    else if (cand_valid && cand_ready) outstanding <= 1'b1;
    else if (cost_valid)               outstanding <= 1'b0;
  end

  AST_CAND_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid && !cand_ready |=> cand_valid && $stable(cand_x) && $stable(cand_y)); // R8
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding |-> !cand_valid); // R8
  AST_CAND_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid |-> (cand_x >= -RANGE) && (cand_x <= RANGE) && (cand_y >= -RANGE) && (cand_y <= RANGE)); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cand_valid && !outstanding); // R9
endmodule

bind sq_search_ctrl sq_search_ctrl_chk #(.MVW(MVW), .RANGE(RANGE)) chk_i (
  .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_ready(cand_ready),
  .cand_x(cand_x), .cand_y(cand_y), .cost_valid(cost_valid), .done(done));

// File: tb/sq_search_ctrl_tb_top.sv
`timescale 1ns/1ps
module sq_search_ctrl_tb_top;
  localparam int MVW = 9;
  localparam int CW  = 16;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic signed [MVW-1:0] left_x = '0, left_y = '0, up_x = '0, up_y = '0, upr_x = '0, upr_y = '0;
  logic [CW-1:0] thresh = '0;
  logic cand_valid, cand_ready = 1'b0;
  logic signed [MVW-1:0] cand_x, cand_y;
  logic cost_valid = 1'b0;
  logic [CW-1:0] cost = '0;
  logic done, pred_used;
  logic signed [MVW-1:0] mv_x, mv_y;
  logic [CW-1:0] mv_cost;

  sq_search_ctrl #(.MVW(MVW), .CW(CW), .RANGE(128)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .left_x(left_x), .left_y(left_y), .up_x(up_x), .up_y(up_y), .upr_x(upr_x), .upr_y(upr_y),
    .thresh(thresh), .cand_valid(cand_valid), .cand_ready(cand_ready),
    .cand_x(cand_x), .cand_y(cand_y), .cost_valid(cost_valid), .cost(cost),
    .done(done), .mv_x(mv_x), .mv_y(mv_y), .mv_cost(mv_cost), .pred_used(pred_used));

  always #2.5 clk = ~clk;

  int nchk = 0, nfail = 0;
  int cmode = 0, tgt_x = 0, tgt_y = 0, cbase = 0;
  int lat_cfg = 0, stall_cfg = 0;
  int n_cand = 0, oor = 0, proto_err = 0, tick = 0, pend = 0, dly = 0, pcx = 0, pcy = 0;
  int rec_x [0:31];
  int rec_y [0:31];
  int got_x, got_y, got_c, got_p;

  function automatic int iabs(int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int cost_of(int x, int y);
    if (cmode == 0) return cbase;
    if (cmode == 1) return cbase + iabs(x - tgt_x) + iabs(y - tgt_y);
    if ((x == 0 && y == -3) || (x == 8 && y == 5)) return 5;
    return 10;
  endfunction

  function automatic int med3(int a, int b, int c);
    int mx, mn;
    mx = (a > b) ? a : b; mx = (c > mx) ? c : mx;
    mn = (a < b) ? a : b; mn = (c < mn) ? c : mn;
    return a + b + c - mx - mn;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // cost engine model
  always @(negedge clk) begin
    if (cost_valid) cost_valid = 1'b0;
    else if (pend != 0) begin
      if (dly == 0) begin
        cost = CW'(cost_of(pcx, pcy));
        cost_valid = 1'b1;
        pend = 0;
      end else dly--;
    end
    tick++;
    cand_ready = (stall_cfg != 0) ? ((tick % 3) != 0) : 1'b1;
    if (cand_valid && (pend != 0 || cost_valid)) proto_err++;
    if (cand_valid && cand_ready) begin
      pcx = int'(cand_x);
      pcy = int'(cand_y);
      if (pcx < -128 || pcx > 128 || pcy < -128 || pcy > 128) oor++;
      if (n_cand < 32) begin rec_x[n_cand] = pcx; rec_y[n_cand] = pcy; end
      n_cand++;
      pend = 1;
      dly = lat_cfg;
    end
  end

  task automatic model(input int px, input int py, input int thr,
                       output int fx, output int fy, output int fc, output int fp, output int fn);
    int cx, cy, st, ph, known, cc, n, bx, by, bc, atc, fin;
    cx = px; cy = py; st = 4; ph = 0; known = 0; cc = 0; n = 0; fin = 0; fp = 0;
    fx = 0; fy = 0; fc = 0;
    for (int g = 0; g < 400 && fin == 0; g++) begin
      if (known == 0) begin cc = cost_of(cx, cy); n++; end
      bx = cx; by = cy; bc = cc; atc = 1;
      for (int k = 1; k < 9; k++) begin
        int ddx, ddy, x, y, c;
        ddx = (k == 1 || k == 4 || k == 6) ? -st : ((k == 3 || k == 5 || k == 8) ? st : 0);
        ddy = (k <= 3) ? -st : ((k >= 6) ? st : 0);
        x = cx + ddx; y = cy + ddy;
        if (x >= -128 && x <= 128 && y >= -128 && y <= 128) begin
          n++;
          c = cost_of(x, y);
          if (c < bc) begin bc = c; bx = x; by = y; atc = 0; end
        end
      end
      if (ph == 0) begin
        if (atc == 1 || bc < thr) begin
          fp = 1; ph = 2; st = 2; cx = bx; cy = by; cc = bc; known = 1;
        end else begin
          ph = 1; st = 8; cx = 0; cy = 0; known = 0;
        end
      end else if (ph == 1) begin
        if (atc == 1) begin ph = 2; st = 4; end
        cx = bx; cy = by; cc = bc; known = 1;
      end else if (st == 1) begin
        fx = bx; fy = by; fc = bc; fin = 1;
      end else begin
        st = st / 2; cx = bx; cy = by; cc = bc; known = 1;
      end
    end
    fn = n;
  endtask

  task automatic run_search(string req, int lx, int ly, int ux, int uy, int rx, int ry,
                            int thr, bit poke);
    int ex, ey, ec, ep, en, w;
    n_cand = 0; oor = 0; proto_err = 0;
    @(negedge clk);
    left_x = MVW'(lx); left_y = MVW'(ly); up_x = MVW'(ux); up_y = MVW'(uy);
    upr_x = MVW'(rx); upr_y = MVW'(ry); thresh = CW'(thr); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (4) @(negedge clk);
      left_x = 9'sd100; up_x = 9'sd100; upr_x = 9'sd100;
      left_y = -9'sd90; up_y = -9'sd90; upr_y = -9'sd90; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    w = 0;
    while (!done && w < 20000) begin @(negedge clk); w++; end
    got_x = int'(mv_x); got_y = int'(mv_y); got_c = int'(mv_cost); got_p = int'(pred_used);
    chk("R9", "done seen", int'(done), 1);
    @(negedge clk);
    chk("R9", "done one cycle", int'(done), 0);
    model(med3(lx, ux, rx), med3(ly, uy, ry), thr, ex, ey, ec, ep, en);
    chk(req, "final x", got_x, ex);
    chk(req, "final y", got_y, ey);
    chk(req, "final cost", got_c, ec);
    chk(req, "pred_used", got_p, ep);
    chk("R6", "candidate count", n_cand, en);
    chk("R1", "first cand x", rec_x[0], med3(lx, ux, rx));
    chk("R1", "first cand y", rec_y[0], med3(ly, uy, ry));
    chk("R5", "out-of-range candidates", oor, 0);
    chk("R8", "protocol errors", proto_err, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R10", "cand_valid in reset", int'(cand_valid), 0);
    chk("R10", "done in reset", int'(done), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10", "cand_valid after reset", int'(cand_valid), 0);
    chk("R10", "done after reset", int'(done), 0);
  endtask

  task automatic t_flat();
    cmode = 0; cbase = 100;
    run_search("R7", 10, -3, 4, 7, -2, 1, 0, 1'b0);
    chk("R7", "flat keeps centre x", got_x, 4);
    chk("R7", "flat keeps centre y", got_y, 1);
    chk("R3", "flat accepted", got_p, 1);
    chk("R6", "flat count 9+8+8", n_cand, 25);
    chk("R2", "second cand x", rec_x[1], 0);
    chk("R2", "second cand y", rec_y[1], -3);
    chk("R2", "ninth cand x", rec_x[8], 8);
    chk("R2", "ninth cand y", rec_y[8], 5);
  endtask

  task automatic t_corner();
    cmode = 0; cbase = 7;
    run_search("R5", 128, 128, 128, 128, 128, 128, 0, 1'b0);
    chk("R5", "corner count", n_cand, 10);
    chk("R5", "corner second cand x", rec_x[1], 124);
    chk("R5", "corner second cand y", rec_y[1], 124);
  endtask

  task automatic t_thresh();
    cmode = 1; cbase = 0; tgt_x = 9; tgt_y = 1;
    run_search("R3", 10, -3, 4, 7, -2, 1, 5, 1'b0);
    chk("R3", "below thresh final x", got_x, 9);
    chk("R3", "below thresh final y", got_y, 1);
    chk("R3", "below thresh cost", got_c, 0);
    chk("R3", "below thresh pred", got_p, 1);
    run_search("R3", 10, -3, 4, 7, -2, 1, 1, 1'b0);
    chk("R3", "equal thresh rejects", got_p, 0);
    chk("R4", "restart at zero x", rec_x[9], 0);
    chk("R4", "restart at zero y", rec_y[9], 0);
    chk("R4", "first step8 point x", rec_x[10], -8);
    chk("R4", "first step8 point y", rec_y[10], -8);
  endtask

  task automatic t_tie();
    cmode = 2;
    run_search("R7", 10, -3, 4, 7, -2, 1, 6, 1'b0);
    chk("R7", "earlier tie kept x", got_x, 0);
    chk("R7", "earlier tie kept y", got_y, -3);
    chk("R7", "tie cost", got_c, 5);
    chk("R3", "tie accepted by thresh", got_p, 1);
  endtask

  task automatic t_far();
    cmode = 1; cbase = 3; tgt_x = 60; tgt_y = -40;
    lat_cfg = 0; stall_cfg = 0;
    run_search("R4", 2, 2, 3, 3, 1, 1, 0, 1'b0);
    chk("R4", "far pred rejected", got_p, 0);
    lat_cfg = 3; stall_cfg = 1;
    run_search("R8", 2, 2, 3, 3, 1, 1, 0, 1'b0);
    lat_cfg = 1; stall_cfg = 0;
    tgt_x = -125; tgt_y = 126;
    run_search("R5", -120, 120, -126, 127, -110, 100, 2, 1'b0);
    lat_cfg = 0;
  endtask

  task automatic t_busy();
    cmode = 1; cbase = 0; tgt_x = -30; tgt_y = 17;
    run_search("R9", -20, 10, -25, 12, 40, -5, 4, 1'b1);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_flat();
    t_corner();
    t_thresh();
    t_tie();
    t_far();
    t_busy();
    finish_run();
  end
endmodule